// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a parallel NOR flash bus. A client hands it one request at a time on a valid/ready handshake: program one location, erase one sector, or erase the whole array. The sequencer expands the request into the unlock and command writes the flash expects, and shapes each write strobe with counts of clock cycles. It then polls the device with status reads until the embedded operation completes.

Completion is found from the status bits and never from a fixed wait. Bit 6 of the status word flips on every read while the device is busy, so two reads in a row that agree mean the work is finished. For a program, bit 7 reads back as the inverse of the written bit 7 while busy and as the true bit once done. If a cycle budget runs out first, the sequencer writes a read/reset command and reports done together with an error. A static input selects byte or word bus width, and this changes the unlock addresses.

Top module: `flash_cmd_seq`

## Requirements
- R1: With `req_op`=0 (program) in word mode, exactly four writes are issued in this order: AAh at 555h, 55h at 2AAh, A0h at 555h, then `req_data` at `req_addr`.
- R2: In byte mode (`byte_mode`=1), the unlock addresses 555h and 2AAh become AAAh and 555h in every sequence. Program data is limited to its low byte, and the upper bits of `fl_dq_out` are zero.
- R3: With `req_op`=1 (sector erase), six writes are issued: AAh, 55h, 80h, AAh and 55h at the unlock addresses (first, second, first, first, second), then 30h at `req_addr`.
- R4: With `req_op`=2 or 3 (chip erase), the first five writes match R3, and the sixth write is 10h at the first unlock address.
- R5: Each write holds `fl_we_n` low for at least P_WLO cycles with `fl_dq_oe` high throughout, and holds it high for at least P_WHI cycles between pulses.
- R6: Each status read holds `fl_oe_n` and `fl_ce_n` low for P_RD cycles with `fl_dq_oe` low. Both stay high for at least P_RHI cycles between successive reads.
- R7: The operation is reported complete at the first status read whose bit 6 equals bit 6 of the previous read in the same operation. It is never reported complete while bit 6 keeps alternating.
- R8: For a program, a status read whose bit 7 equals bit 7 of the written data also marks completion. While bit 7 reads as its complement, polling continues.
- R9: If the operation has not completed once TO_PROG cycles (program) or TO_ERASE cycles (erase) of polling have elapsed, one more write of F0h at address 0 is issued. `done` and `err` are then raised together.
- R10: `req_ready` is high only when idle and falls in the cycle after a request is accepted. `done` is a single-cycle pulse, and `req_ready` is high again in the cycle after it.
- R11: After reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, `fl_dq_oe`, `done` and `err` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects byte bus width, 0 selects word width; change only while idle |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_op | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| req_addr | input | AW | Program address or sector address |
| req_data | input | DW | Data to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Valid with `done`: operation timed out |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Data driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | DW | Data read from the flash |

## Verification
Each status read is sampled on the last cycle of its low phase. `done` rises one cycle after the clock edge that samples the deciding read, and `req_ready` returns one cycle after that. The bench drives requests on falling edges and waits for `done` on falling edges. After `done` it waits three more cycles before comparing the write log and the read count, so the responder has recorded the final rising edge of `fl_oe_n`. The expected read count follows from how many busy reads the responder was told to give: one read after the busy ones for a program, and one or two for an erase, depending on the phase of the toggle bit.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int P_WLO    = 10,
  parameter int P_WHI    = 6,
  parameter int P_RD     = 20,
  parameter int P_RHI    = 4,
  parameter int TO_PROG  = 60000,
  parameter int TO_ERASE = 2000000000,
  parameter int TW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          done,
  output logic          err,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in
);
  localparam int PM1  = (P_WLO > P_WHI) ? P_WLO : P_WHI;
  localparam int PM2  = (P_RD > P_RHI) ? P_RD : P_RHI;
  localparam int PMAX = (PM1 > PM2) ? PM1 : PM2;
  localparam int CW   = $clog2(PMAX + 1);
  localparam logic [1:0] OP_PROG = 2'd0;
  localparam logic [1:0] OP_SECT = 2'd1;

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    wi;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q, u1, u2, w_addr;
  logic [DW-1:0] data_q, w_data;
  logic          bm_q, abort_q, err_q, have_prev, prev6;
  logic [TW-1:0] tmo;
  logic          last, hit, expired;
  logic          unused_bits;

  assign u1      = bm_q ? AW'(12'hAAA) : AW'(12'h555);
  assign u2      = bm_q ? AW'(12'h555) : AW'(12'h2AA);
  assign last    = (op_q == OP_PROG) ? (wi == 3'd3) : (wi == 3'd5);
  assign hit     = (have_prev && (fl_dq_in[6] == prev6)) ||
                   ((op_q == OP_PROG) && (fl_dq_in[7] == data_q[7]));
  assign expired = tmo >= TW'((op_q == OP_PROG) ? TO_PROG : TO_ERASE);
  assign unused_bits = ^{fl_dq_in[DW-1:8], fl_dq_in[5:0]};

  always_comb begin
    w_addr = u1;
    w_data = DW'(8'hAA);
    if (abort_q) begin
      w_addr = '0;
      w_data = DW'(8'hF0);
    end else begin
      case (wi)
        3'd1, 3'd4: begin w_addr = u2; w_data = DW'(8'h55); end
        3'd2: w_data = (op_q == OP_PROG) ? DW'(8'hA0) : DW'(8'h80);
        3'd3: if (op_q == OP_PROG) begin
          w_addr = addr_q;
          w_data = bm_q ? {{(DW-8){1'b0}}, data_q[7:0]} : data_q;
        end
        3'd5: if (op_q == OP_SECT) begin
          w_addr = addr_q;
          w_data = DW'(8'h30);
        end else begin
          w_data = DW'(8'h10);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wi <= '0; op_q <= '0; addr_q <= '0; data_q <= '0;
      bm_q <= 1'b0; abort_q <= 1'b0; err_q <= 1'b0; have_prev <= 1'b0;
      prev6 <= 1'b0; tmo <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; addr_q <= req_addr; data_q <= req_data; bm_q <= byte_mode;
          wi <= '0; abort_q <= 1'b0; err_q <= 1'b0; have_prev <= 1'b0; tmo <= '0;
          cnt <= CW'(P_WLO - 1);
          st <= S_WLO;
        end
        S_WLO:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin cnt <= CW'(P_WHI - 1); st <= S_WHI; end
        S_WHI:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (abort_q) begin err_q <= 1'b1; st <= S_DONE; end
          else if (last) begin cnt <= CW'(P_RD - 1); st <= S_RLO; end
          else begin wi <= wi + 1'b1; cnt <= CW'(P_WLO - 1); st <= S_WLO; end
        S_RLO: begin
          tmo <= tmo + 1'b1;
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (hit) st <= S_DONE;
          else if (expired) begin abort_q <= 1'b1; cnt <= CW'(P_WLO - 1); st <= S_WLO; end
          else begin
            prev6 <= fl_dq_in[6]; have_prev <= 1'b1;
            cnt <= CW'(P_RHI - 1); st <= S_RHI;
          end
        end
        S_RHI: begin
          tmo <= tmo + 1'b1;
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin cnt <= CW'(P_RD - 1); st <= S_RLO; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign err       = done && err_q;
  assign fl_we_n   = !(st == S_WLO);
  assign fl_oe_n   = !(st == S_RLO);
  assign fl_ce_n   = !((st == S_WLO) || (st == S_RLO));
  assign fl_dq_oe  = (st == S_WLO) || (st == S_WHI);
  assign fl_addr   = ((st == S_RLO) || (st == S_RHI)) ? addr_q : w_addr;
  assign fl_dq_out = w_data;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int P_WLO = 10,
  parameter int P_WHI = 6,
  parameter int P_RD  = 20,
  parameter int P_RHI = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic err,
  input logic fl_ce_n,
  input logic fl_we_n,
  input logic fl_oe_n,
  input logic fl_dq_oe
);
  logic [15:0] we_lo, we_hi, oe_lo, oe_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo <= '0; we_hi <= '1; oe_lo <= '0; oe_hi <= '1;
    end else begin
      if (!fl_we_n) begin
        we_lo <= (we_lo == 16'hFFFF) ? we_lo : we_lo + 1'b1;
        we_hi <= '0;
      end else begin
        we_hi <= (we_hi == 16'hFFFF) ? we_hi : we_hi + 1'b1;
        we_lo <= '0;
      end
      if (!fl_oe_n) begin
        oe_lo <= (oe_lo == 16'hFFFF) ? oe_lo : oe_lo + 1'b1;
        oe_hi <= '0;
      end else begin
        oe_hi <= (oe_hi == 16'hFFFF) ? oe_hi : oe_hi + 1'b1;
        oe_lo <= '0;
      end
    end
  end

  a_r5_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> int'(we_lo) >= P_WLO);
  a_r5_we_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> int'(we_hi) >= P_WHI);
  a_r5_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_dq_oe);
  a_r6_read_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_oe_n) |-> int'(oe_lo) >= P_RD);
  a_r6_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> int'(oe_hi) >= P_RHI);
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_dq_oe && !fl_ce_n));
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  a_r10_accept_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .P_WLO(P_WLO), .P_WHI(P_WHI), .P_RD(P_RD), .P_RHI(P_RHI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .err(err), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
  .fl_oe_n(fl_oe_n), .fl_dq_oe(fl_dq_oe)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int AW = 20, DW = 16, WLO = 3, WHI = 2, RD = 4, RHI = 2;
  localparam int TOP = 400, TOE = 800;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic byte_mode = 1'b0, req_valid = 1'b0, req_ready, done, err;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0, fl_addr;
  logic [DW-1:0] req_data = '0, fl_dq_out, fl_dq_in;
  logic fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;

  flash_cmd_seq #(.AW(AW), .DW(DW), .P_WLO(WLO), .P_WHI(WHI), .P_RD(RD), .P_RHI(RHI),
                  .TO_PROG(TOP), .TO_ERASE(TOE)) dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in));

  int checks = 0, errors = 0;

  // responder model
  logic arm = 1'b0, cfg7 = 1'b0;
  int cfg_busy = 0;
  logic [DW-1:0] cfg_fin = '0;
  int busy_left = 0, rd_count = 0, nwr = 0, lo_len = 0, min_lo = 1000;
  logic tog = 1'b0, b7 = 1'b0, drv_ok = 1'b1, prev_we_n = 1'b1, prev_oe_n = 1'b1;
  logic [DW-1:0] fin = '0, ld = '0;
  logic [AW-1:0] la = '0;
  logic [AW-1:0] wa [0:7];
  logic [DW-1:0] wd [0:7];

  assign fl_dq_in = (busy_left > 0) ? DW'({b7, tog, 6'b0}) : fin;

  always @(posedge clk) begin
    if (arm) begin
      busy_left <= cfg_busy; tog <= 1'b0; b7 <= cfg7; fin <= cfg_fin;
      rd_count <= 0; nwr <= 0; min_lo <= 1000; drv_ok <= 1'b1; lo_len <= 0;
    end else begin
      if (!fl_we_n) begin
        la <= fl_addr; ld <= fl_dq_out; lo_len <= lo_len + 1;
        if (!fl_dq_oe) drv_ok <= 1'b0;
      end else if (!prev_we_n) begin
        if (nwr < 8) begin wa[nwr] <= la; wd[nwr] <= ld; end
        nwr <= nwr + 1;
        if (lo_len < min_lo) min_lo <= lo_len;
        lo_len <= 0;
      end
      if (fl_oe_n && !prev_oe_n) begin
        rd_count <= rd_count + 1;
        if (busy_left > 0) begin busy_left <= busy_left - 1; tog <= ~tog; end
      end
    end
    prev_we_n <= fl_we_n;
    prev_oe_n <= fl_oe_n;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_a(int op, logic bm, int i, logic [AW-1:0] a, bit to);
    logic [AW-1:0] u1, u2;
    int lst;
    u1 = bm ? AW'(12'hAAA) : AW'(12'h555);
    u2 = bm ? AW'(12'h555) : AW'(12'h2AA);
    lst = (op == 0) ? 3 : 5;
    if (to && i == lst + 1) return '0;
    case (i)
      1, 4: return u2;
      3: return (op == 0) ? a : u1;
      5: return (op == 1) ? a : u1;
      default: return u1;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_d(int op, int i, logic [DW-1:0] dm, bit to);
    int lst;
    lst = (op == 0) ? 3 : 5;
    if (to && i == lst + 1) return DW'(8'hF0);
    case (i)
      1, 4: return DW'(8'h55);
      2: return (op == 0) ? DW'(8'hA0) : DW'(8'h80);
      3: return (op == 0) ? dm : DW'(8'hAA);
      5: return (op == 1) ? DW'(8'h30) : DW'(8'h10);
      default: return DW'(8'hAA);
    endcase
  endfunction

  task automatic run(input int op_in, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic bm, input int busy, input bit to_exp);
    int op, n_exp, r_exp, waited;
    logic got_err;
    logic [DW-1:0] dm;
    string tag;
    bit seq_ok;
    op = (op_in > 1) ? 2 : op_in;
    tag = bm ? "R2" : (op == 0 ? "R1" : (op == 1 ? "R3" : "R4"));
    dm = bm ? (d & DW'(16'h00FF)) : d;
    @(negedge clk);
    byte_mode = bm; cfg_busy = busy; cfg7 = (op == 0) ? ~d[7] : 1'b0;
    cfg_fin = (op == 0) ? dm : '1; arm = 1'b1;
    req_op = op_in[1:0]; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    arm = 1'b0; req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready after accept", req_ready, 0);
    waited = 0;
    while (!done && waited < 20000) begin @(negedge clk); waited++; end
    got_err = err;
    chk(done == 1'b1, "R7", "done seen", done, 1);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after done", req_ready, 1);
    n_exp = ((op == 0) ? 4 : 6) + (to_exp ? 1 : 0);
    chk(nwr == n_exp, tag, "write count", nwr, n_exp);
    seq_ok = 1'b1;
    for (int i = 0; i < n_exp && i < 8; i++) begin
      if (wa[i] !== exp_a(op, bm, i, a, to_exp) || wd[i] !== exp_d(op, i, dm, to_exp)) begin
        if (seq_ok) chk(1'b0, to_exp ? "R9" : tag, $sformatf("write %0d addr/data", i),
                        {wa[i], wd[i]}, {exp_a(op, bm, i, a, to_exp), exp_d(op, i, dm, to_exp)});
        seq_ok = 1'b0;
      end
    end
    if (seq_ok) chk(1'b1, tag, "write sequence", 0, 0);
    chk(min_lo >= WLO && drv_ok, "R5", "write strobe width", min_lo, WLO);
    chk(got_err == to_exp, "R9", "error flag", got_err, to_exp);
    if (!to_exp) begin
      if (op == 0) r_exp = busy + 1;
      else if (busy == 0) r_exp = 2;
      else r_exp = (((busy - 1) % 2) == 1) ? busy + 1 : busy + 2;
      chk(rd_count == r_exp, (op == 0) ? "R8" : "R7", "status reads", rd_count, r_exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R11", "strobes in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    chk(!fl_dq_oe && !done && !err && req_ready, "R11", "flags in reset",
        {fl_dq_oe, done, err, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(0, 20'h12345, 16'hBEEF, 1'b0, 5, 1'b0);
    run(0, 20'h00F00, 16'h1234, 1'b0, 0, 1'b0);
    run(0, 20'hABCDE, 16'hCD80, 1'b1, 3, 1'b0);
    run(1, 20'h40000, 16'h0000, 1'b0, 0, 1'b0);
    run(1, 20'h70000, 16'h0000, 1'b1, 1, 1'b0);
    run(2, 20'h00000, 16'h0000, 1'b0, 2, 1'b0);
    run(3, 20'h00000, 16'h0000, 1'b1, 7, 1'b0);
    run(0, 20'h00010, 16'h0055, 1'b0, 5000, 1'b1);
    run(1, 20'h20000, 16'h0000, 1'b0, 5000, 1'b1);
    // random requests
    for (int k = 0; k < 24; k++) begin
      run(int'($urandom_range(0, 3)), AW'($urandom), DW'($urandom),
          1'($urandom_range(0, 1)), int'($urandom_range(0, 12)), 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule